// File: doc/BRIEF.md
# Maskable Interrupt Status Controller

This block gathers eight single-cycle event pulses from neighbouring logic into sticky status flags. Each flag has its own enable. A single interrupt pin is asserted while any flag is both set and enabled. The pin's active level is programmable, and after reset the pin is active low.

Software reaches the block through a simple register port with separate read and write strobes. The control/status word sits at address 27. Its upper byte holds the enables and its lower byte holds the status flags. Reading that word clears the status flags as a side effect. Address 31 holds a single polarity bit at position 14.

A status flag is recorded whether or not its enable is set. The enables only gate the pin. If an event lands in the same cycle as a clearing read, it is kept, so no event is lost.

Top module: `irq_status_ctrl`

## Requirements
- R1: After reset, every enable and every status flag is 0, the polarity bit is 0, and `irq_pin` is 1 (the inactive level for active low).
- R2: A 1 on `evt_pulse[i]` at a clock edge sets status flag i after that edge, whatever the value of enable i. A set flag stays set until a clearing read.
- R3: While `reg_rd` is 1 and `reg_addr` is 27, `reg_rdata` shows enables in bits 15:8 and status in bits 7:0, with status bit i belonging to `evt_pulse[i]`.
- R4: A read of address 27 clears every status flag at the same clock edge that ends the read.
- R5: An event pulse in the same cycle as a clearing read leaves that status flag set after the edge.
- R6: A write to address 27 loads bits 15:8 of `reg_wdata` into the enables and leaves the status flags unchanged.
- R7: One cycle after any flag and its matching enable are both 1, `irq_pin` is at the active level. Otherwise, one cycle later, it is at the inactive level.
- R8: Bit 14 at address 31 is the polarity: 0 means active low and 1 means active high. Only that bit is stored, and all other bits of address 31 read 0.
- R9: Reads of addresses other than 27 and 31 return 0, and writes to them change nothing.
- R10: A read of address 31 leaves the status flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| evt_pulse | input | 8 | Event pulses, one per condition |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; a read of 27 clears status |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid while `reg_rd` is 1, otherwise 0 |
| irq_pin | output | 1 | Interrupt pin at the programmed level |

## Verification
The bench drives an event into the very cycle of a clearing read. A design that applied the clear with priority would drop that event and return 0 on the next read.

It writes all ones to the control word and checks that the status flags still read 0. A design that let writes reach the status bits would show spurious events.

It records a flag whose enable is off, then checks that the flag is captured while the pin stays quiet. This catches designs that either skip recording or fail to mask the pin. It also reads address 31 and other addresses, then confirms the status survived. This catches address decoding that clears on any read.

// File: rtl/irq_pkg.sv
package irq_pkg;
  // register access decode result
  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_CSR  = 2'd1,
    ACC_CFG  = 2'd2
  } acc_sel_e;
endpackage

// File: rtl/irq_evt_latch.sv
module irq_evt_latch #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt_i,
  input  logic         clr_i,
  output logic [N-1:0] stat_o
);
  logic [N-1:0] stat_q;
  logic [N-1:0] stat_d;

  for (genvar g = 0; g < N; g++) begin : g_bit
    // new event wins over a clear landing in the same cycle
    always_comb begin
      stat_d[g] = stat_q[g];
      if (clr_i) stat_d[g] = 1'b0;
      if (evt_i[g]) stat_d[g] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q[g] <= 1'b0;
      else        stat_q[g] <= stat_d[g];
    end
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/irq_csr.sv
module irq_csr
  import irq_pkg::*;
#(
  parameter int unsigned N        = 8,
  parameter int unsigned AW       = 5,
  parameter int unsigned CSR_ADDR = 27,
  parameter int unsigned CFG_ADDR = 31,
  parameter int unsigned POL_BIT  = 14,
  localparam int unsigned DW      = 2 * N
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [N-1:0]  stat_i,
  output logic [N-1:0]  en_o,
  output logic          pol_o,
  output logic          clr_o,
  output logic [DW-1:0] rdata_o
);
  acc_sel_e     sel;
  logic [N-1:0] en_q, en_d;
  logic         en_ce;
  logic         pol_q, pol_d;
  logic         pol_ce;

  always_comb begin
    if (addr_i == AW'(CSR_ADDR))      sel = ACC_CSR;
    else if (addr_i == AW'(CFG_ADDR)) sel = ACC_CFG;
    else                              sel = ACC_NONE;
  end

  // next-state
  always_comb begin
    en_ce  = wr_i && (sel == ACC_CSR);
    en_d   = wdata_i[DW-1:N];
    pol_ce = wr_i && (sel == ACC_CFG);
    pol_d  = wdata_i[POL_BIT];
  end

  // registers with explicit clock enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_ce) en_q <= en_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pol_q <= 1'b0;
    else if (pol_ce) pol_q <= pol_d;
  end

  // read path
  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      unique case (sel)
        ACC_CSR: rdata_o = {en_q, stat_i};
        ACC_CFG: rdata_o[POL_BIT] = pol_q;
        default: rdata_o = '0;
      endcase
    end
  end

  assign clr_o = rd_i && (sel == ACC_CSR);
  assign en_o  = en_q;
  assign pol_o = pol_q;
endmodule

// File: rtl/irq_pin_drv.sv
module irq_pin_drv #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] stat_i,
  input  logic [N-1:0] en_i,
  input  logic         pol_i,
  output logic         pin_o
);
  logic pend;
  logic pin_d, pin_q;

  always_comb begin
    pend  = |(stat_i & en_i);
    pin_d = pol_i ? pend : ~pend;
  end

  // reset level is inactive for the default active-low polarity
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b1;
    else        pin_q <= pin_d;
  end

  assign pin_o = pin_q;
endmodule

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl #(
  parameter int unsigned NUM_EVT  = 8,
  parameter int unsigned ADDR_W   = 5,
  parameter int unsigned CSR_ADDR = 27,
  parameter int unsigned CFG_ADDR = 31,
  parameter int unsigned POL_BIT  = 14,
  localparam int unsigned DATA_W  = 2 * NUM_EVT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EVT-1:0] evt_pulse,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_pin
);
  logic [1:0]         rst_sync_q;
  logic               rst_sync_n;
  logic [NUM_EVT-1:0] stat;
  logic [NUM_EVT-1:0] en;
  logic               pol;
  logic               clr;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  irq_evt_latch #(.N(NUM_EVT)) u_latch (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .evt_i  (evt_pulse),
    .clr_i  (clr),
    .stat_o (stat)
  );

  irq_csr #(
    .N        (NUM_EVT),
    .AW       (ADDR_W),
    .CSR_ADDR (CSR_ADDR),
    .CFG_ADDR (CFG_ADDR),
    .POL_BIT  (POL_BIT)
  ) u_csr (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_i    (reg_wr),
    .rd_i    (reg_rd),
    .addr_i  (reg_addr),
    .wdata_i (reg_wdata),
    .stat_i  (stat),
    .en_o    (en),
    .pol_o   (pol),
    .clr_o   (clr),
    .rdata_o (reg_rdata)
  );

  irq_pin_drv #(.N(NUM_EVT)) u_pin (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .stat_i (stat),
    .en_i   (en),
    .pol_i  (pol),
    .pin_o  (irq_pin)
  );
endmodule

// File: rtl/irq_status_ctrl_chk.sv
module irq_status_ctrl_chk #(
  parameter int unsigned N        = 8,
  parameter int unsigned AW       = 5,
  parameter int unsigned CSR_ADDR = 27,
  parameter int unsigned CFG_ADDR = 31,
  localparam int unsigned DW      = 2 * N
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  evt,
  input logic          rd,
  input logic          wr,
  input logic [AW-1:0] addr,
  input logic [N-1:0]  wen,
  input logic [DW-1:0] rdata,
  input logic [N-1:0]  stat,
  input logic [N-1:0]  en,
  input logic          pol,
  input logic          pin
);
  logic csr_rd;
  logic csr_wr;
  assign csr_rd = rd && (addr == AW'(CSR_ADDR));
  assign csr_wr = wr && (addr == AW'(CSR_ADDR));

  assert_evt_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt != '0) |=> ((stat & $past(evt)) == $past(evt)));

  assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_rd |=> ((stat & $past(stat)) == $past(stat)));

  assert_rdata_R3: assert property (@(posedge clk) disable iff (!rst_n)
    csr_rd |-> (rdata == {en, stat}));

  assert_clear_R4_R5: assert property (@(posedge clk) disable iff (!rst_n)
    csr_rd |=> (stat == $past(evt)));

  assert_wr_en_R6: assert property (@(posedge clk) disable iff (!rst_n)
    csr_wr |=> (en == $past(wen)));

  assert_pin_R7_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pin == ($past(|(stat & en)) ~^ $past(pol))));

  assert_idle_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd) |-> (rdata == '0));

  // the other address bits are only decoded here
  assert_cfg_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && (addr == AW'(CFG_ADDR))) |=> ((stat & $past(stat)) == $past(stat)));
endmodule

bind irq_status_ctrl irq_status_ctrl_chk #(
  .N        (NUM_EVT),
  .AW       (ADDR_W),
  .CSR_ADDR (CSR_ADDR),
  .CFG_ADDR (CFG_ADDR)
) u_chk (
  .clk   (clk),
  .rst_n (rst_sync_n),
  .evt   (evt_pulse),
  .rd    (reg_rd),
  .wr    (reg_wr),
  .addr  (reg_addr),
  .wen   (reg_wdata[DATA_W-1:NUM_EVT]),
  .rdata (reg_rdata),
  .stat  (stat),
  .en    (en),
  .pol   (pol),
  .pin   (irq_pin)
);

// File: tb/tb_irq_status_ctrl.sv
`timescale 1ns/1ps
module tb_irq_status_ctrl;
  logic        clk;
  logic        rst_n;
  logic [7:0]  evt_pulse;
  logic        reg_wr;
  logic        reg_rd;
  logic [4:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic        irq_pin;

  int n_chk;
  int n_fail;

  irq_status_ctrl dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_pulse (evt_pulse),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .irq_pin   (irq_pin)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk16(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk1(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic pulse(input logic [7:0] v);
    evt_pulse = v;
    tick();
    evt_pulse = '0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    reg_rd   = 1'b1;
    reg_addr = a;
    #1 d = reg_rdata;
    tick();
    reg_rd = 1'b0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    reg_wr    = 1'b1;
    reg_addr  = a;
    reg_wdata = d;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    chk1("R1 pin after reset", irq_pin, 1'b1);
    rd(5'd27, d); chk16("R1 control word after reset", d, 16'h0000);
    rd(5'd31, d); chk16("R1 polarity after reset", d, 16'h0000);
  endtask

  task automatic t_unmasked_record();
    logic [15:0] d;
    pulse(8'h05);
    tick();
    chk1("R2 pin quiet with enables off", irq_pin, 1'b1);
    rd(5'd27, d); chk16("R2 R3 flags recorded", d, 16'h0005);
    rd(5'd27, d); chk16("R4 flags cleared by read", d, 16'h0000);
  endtask

  task automatic t_mask_pin();
    logic [15:0] d;
    wr(5'd27, 16'h0200);
    pulse(8'h01);
    tick();
    chk1("R7 masked flag keeps pin inactive", irq_pin, 1'b1);
    pulse(8'h02);
    chk1("R7 pin one cycle behind flag", irq_pin, 1'b1);
    tick();
    chk1("R7 pin active low", irq_pin, 1'b0);
    rd(5'd27, d); chk16("R3 enables and flags", d, 16'h0203);
    chk1("R7 pin lags the clear", irq_pin, 1'b0);
    tick();
    chk1("R7 pin released after clear", irq_pin, 1'b1);
  endtask

  task automatic t_write_enables();
    logic [15:0] d;
    wr(5'd27, 16'hFFFF);
    rd(5'd27, d); chk16("R6 write sets only enables", d, 16'hFF00);
    wr(5'd27, 16'h0000);
    pulse(8'h80);
    wr(5'd27, 16'h00FF);
    rd(5'd27, d); chk16("R6 write keeps flags", d, 16'h0080);
    rd(5'd27, d); chk16("R4 cleared", d, 16'h0000);
  endtask

  task automatic t_collision();
    logic [15:0] d;
    pulse(8'h10);
    evt_pulse = 8'h20;
    rd(5'd27, d);
    evt_pulse = '0;
    chk16("R3 read before collision", d, 16'h0010);
    rd(5'd27, d); chk16("R5 event in clearing cycle kept", d, 16'h0020);
    rd(5'd27, d); chk16("R4 cleared", d, 16'h0000);
  endtask

  task automatic t_polarity();
    logic [15:0] d;
    wr(5'd31, 16'hFFFF);
    rd(5'd31, d); chk16("R8 only polarity bit stored", d, 16'h4000);
    chk1("R8 pin inactive high after switch", irq_pin, 1'b0);
    wr(5'd27, 16'h0800);
    pulse(8'h08);
    tick();
    chk1("R8 pin active high", irq_pin, 1'b1);
    rd(5'd27, d);
    tick();
    chk1("R8 pin inactive after clear", irq_pin, 1'b0);
    wr(5'd31, 16'h0000);
    tick();
    chk1("R8 back to active low idle", irq_pin, 1'b1);
    wr(5'd27, 16'h0000);
  endtask

  task automatic t_other_addr();
    logic [15:0] d;
    pulse(8'h40);
    rd(5'd31, d); chk16("R10 polarity read", d, 16'h0000);
    rd(5'd5, d);  chk16("R9 other address reads zero", d, 16'h0000);
    wr(5'd5, 16'hFFFF);
    rd(5'd27, d); chk16("R9 R10 status and enables untouched", d, 16'h0040);
    rd(5'd31, d); chk16("R9 stray write ignored", d, 16'h0000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    n_chk     = 0;
    n_fail    = 0;
    rst_n     = 1'b0;
    evt_pulse = '0;
    reg_wr    = 1'b0;
    reg_rd    = 1'b0;
    reg_addr  = '0;
    reg_wdata = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();
    t_reset();
    t_unmasked_record();
    t_mask_pin();
    t_write_enables();
    t_collision();
    t_polarity();
    t_other_addr();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule